// File: doc/BRIEF.md
# Single-Precision Float to Unsigned Integer Truncating Converter

This block turns an IEEE-754 single-precision operand into a 32-bit unsigned integer. It always discards the fractional part, so it rounds toward zero and ignores any rounding mode held elsewhere in the chip. With every result it reports two exception outputs. The invalid output marks an operand that has no unsigned value: a NaN, a negative number, or a magnitude too large for 32 bits. The inexact output marks a legal conversion that dropped fraction bits. An operand with an all-zero exponent field is treated as zero, so denormals flush to zero before conversion.

An operand arrives with a valid strobe. The result, both flags and an output valid appear one clock later. A new operand can be accepted on every cycle. The conversion result for any negative operand is zero with invalid, even a small one such as -0.5 that would otherwise truncate to zero. A NaN also yields zero. Invalid always masks inexact.

Top module: `f2u_trunc_conv`

## Requirements
- R1: `out_valid` is high on the cycle after each cycle on which `in_valid` is high and low otherwise; operands may arrive on consecutive cycles.
- R2: A positive operand below 2^32 yields the largest integer not greater than its value (truncation toward zero).
- R3: A positive in-range operand whose discarded fraction is nonzero, including values strictly between 0 and 1 (which yield 0), raises `out_inexact` and not `out_invalid`.
- R4: A positive operand that is an exact integer up to 2^32-1, including values of 2^24 and above, converts with both flags low.
- R5: An operand with exponent field all ones and a nonzero mantissa (a NaN of either sign, quiet or signaling) yields 0 with `out_invalid` high and `out_inexact` low.
- R6: A nonzero, non-NaN operand with sign bit 1 (including -infinity and values between -1 and 0) yields 0 with `out_invalid` high and `out_inexact` low.
- R7: +infinity and positive operands of 2^32 or more yield 0xFFFFFFFF with `out_invalid` high and `out_inexact` low.
- R8: An operand whose exponent field is zero (either sign of zero, any denormal) yields 0 with both flags low.
- R9: During and straight after reset, `out_valid`, `out_data` and both flags are 0.
- R10: On a cycle after `in_valid` was low, `out_data` and both flags keep their previous values.
- R11: `out_invalid` and `out_inexact` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | Single-precision operand (bit 31 sign, bits 30:23 exponent, bits 22:0 mantissa) |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 32 | Unsigned integer result |
| out_invalid | output | 1 | Operand had no unsigned value |
| out_inexact | output | 1 | Nonzero fraction was discarded |

## Verification
The two functions that meet in one cycle are the range test that can raise invalid and the fraction test that can raise inexact. Both see the same operand, and only the ordering between them decides which flag appears. The sweep reaches every exponent code with both signs and with mantissas that have full, empty and alternating fraction bits. So negative fractions, operands just under and at 2^32, and NaNs with fraction bits set all present both conditions at once. Each result is judged against an integer model that scales the 24-bit significand by the exponent minus 150 and requires exactly one flag or none.

// File: rtl/f2u_pkg.sv
package f2u_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO  = 3'd0,
    CLS_NAN   = 3'd1,
    CLS_NEG   = 3'd2,
    CLS_OVF   = 3'd3,
    CLS_FRAC  = 3'd4,
    CLS_NORM  = 3'd5
  } f2u_class_e;

  localparam int unsigned SP_EXP_W = 8;
  localparam int unsigned SP_MAN_W = 23;
  localparam int unsigned U_OUT_W  = 32;

endpackage

// File: rtl/f2u_decode.sv
module f2u_decode
  import f2u_pkg::*;
#(
  parameter int unsigned EXP_W = SP_EXP_W,
  parameter int unsigned MAN_W = SP_MAN_W,
  parameter int unsigned OUT_W = U_OUT_W,
  localparam int unsigned SH_W = $clog2(OUT_W),
  localparam int unsigned OP_W = EXP_W + MAN_W + 1
) (
  input  logic [OP_W-1:0]  op,
  output f2u_class_e       cls,
  output logic [SH_W-1:0]  shamt,
  output logic [MAN_W:0]   sig
);

  localparam int unsigned BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int unsigned EXP_TOP = (1 << EXP_W) - 1;

  logic             sgn;
  logic [EXP_W-1:0] expf;
  logic [MAN_W-1:0] manf;
  logic [EXP_W:0]   exp_x;
  logic [EXP_W:0]   unb;

  assign sgn   = op[OP_W-1];
  assign expf  = op[OP_W-2:MAN_W];
  assign manf  = op[MAN_W-1:0];
  assign exp_x = {1'b0, expf};
  assign unb   = exp_x - (EXP_W+1)'(BIAS);
  assign shamt = unb[SH_W-1:0];
  assign sig   = {1'b1, manf};

  always_comb begin
    if (expf == '0)                                  cls = CLS_ZERO;
    else if (expf == EXP_W'(EXP_TOP) && manf != '0)  cls = CLS_NAN;
    else if (sgn)                                    cls = CLS_NEG;
    else if (expf == EXP_W'(EXP_TOP))                cls = CLS_OVF;
    else if (exp_x < (EXP_W+1)'(BIAS))               cls = CLS_FRAC;
    else if (exp_x >= (EXP_W+1)'(BIAS + OUT_W))      cls = CLS_OVF;
    else                                             cls = CLS_NORM;
  end

endmodule

// File: rtl/f2u_align.sv
module f2u_align #(
  parameter int unsigned MAN_W = 23,
  parameter int unsigned OUT_W = 32,
  localparam int unsigned SH_W = $clog2(OUT_W),
  localparam int unsigned EXT_W = MAN_W + OUT_W
) (
  input  logic [MAN_W:0]   sig,
  input  logic [SH_W-1:0]  shamt,
  output logic [OUT_W-1:0] whole,
  output logic             frac_nz
);

  function automatic logic [EXT_W-1:0] place(input logic [MAN_W:0] s,
                                             input logic [SH_W-1:0] k);
    logic [EXT_W-1:0] wide;
    wide = EXT_W'(s);
    return wide << k;
  endfunction

  logic [EXT_W-1:0] ext;

  assign ext     = place(sig, shamt);
  assign whole   = ext[EXT_W-1:MAN_W];
  assign frac_nz = |ext[MAN_W-1:0];

endmodule

// File: rtl/f2u_trunc_conv.sv
module f2u_trunc_conv
  import f2u_pkg::*;
#(
  parameter int unsigned EXP_W = SP_EXP_W,
  parameter int unsigned MAN_W = SP_MAN_W,
  parameter int unsigned OUT_W = U_OUT_W,
  localparam int unsigned SH_W = $clog2(OUT_W),
  localparam int unsigned OP_W = EXP_W + MAN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_invalid,
  output logic             out_inexact
);

  f2u_class_e       cls;
  logic [SH_W-1:0]  shamt;
  logic [MAN_W:0]   sig;
  logic [OUT_W-1:0] whole;
  logic             frac_nz;

  f2u_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(OUT_W)) i_decode (
    .op(in_data), .cls(cls), .shamt(shamt), .sig(sig)
  );

  f2u_align #(.MAN_W(MAN_W), .OUT_W(OUT_W)) i_align (
    .sig(sig), .shamt(shamt), .whole(whole), .frac_nz(frac_nz)
  );

  // named events for the checks below
  logic ev_nan, ev_neg, ev_ovf, ev_zero, ev_frac, ev_norm;
  assign ev_nan  = (cls == CLS_NAN);
  assign ev_neg  = (cls == CLS_NEG);
  assign ev_ovf  = (cls == CLS_OVF);
  assign ev_zero = (cls == CLS_ZERO);
  assign ev_frac = (cls == CLS_FRAC);
  assign ev_norm = (cls == CLS_NORM);

  logic [OUT_W-1:0] res_d;
  logic             inv_d, inx_d;

  // invalid has priority: inexact is only ever set on a legal conversion
  always_comb begin
    res_d = '0;
    inv_d = 1'b0;
    inx_d = 1'b0;
    unique case (cls)
      CLS_NAN, CLS_NEG: inv_d = 1'b1;
      CLS_OVF: begin
        res_d = '1;
        inv_d = 1'b1;
      end
      CLS_FRAC: inx_d = 1'b1;
      CLS_NORM: begin
        res_d = whole;
        inx_d = frac_nz;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= res_d;
        out_invalid <= inv_d;
        out_inexact <= inx_d;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_frac_inexact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_frac) |=> (out_data == '0 && out_inexact && !out_invalid));
  assert_nan_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_nan) |=> (out_data == '0 && out_invalid && !out_inexact));
  assert_negative_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_neg) |=> (out_data == '0 && out_invalid && !out_inexact));
  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_ovf) |=> (&out_data && out_invalid && !out_inexact));
  assert_flush_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_zero) |=> (out_data == '0 && !out_invalid && !out_inexact));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_invalid) && $stable(out_inexact)));
  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_invalid && out_inexact));

endmodule

// File: tb/test_f2u_trunc_conv.sv
module test_f2u_trunc_conv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_invalid;
  logic        out_inexact;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        e_valid = 1'b0;
  logic [31:0] e_data = '0;
  logic        e_inv = 1'b0;
  logic        e_inx = 1'b0;
  string       e_tag = "R9";

  always #10 clk = ~clk;

  f2u_trunc_conv i_f2u_trunc_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  // value = sig * 2^(e-150); integer scaling model
  function automatic void model(input logic [31:0] d, output logic [31:0] r,
                                output logic inv, output logic inx, output string tag);
    int e;
    longint unsigned sg, v;
    e = int'(d[30:23]);
    r = '0; inv = 1'b0; inx = 1'b0;
    sg = {40'd0, 1'b1, d[22:0]};
    if (e == 0) tag = "R8";
    else if (e == 255 && d[22:0] != 0) begin inv = 1'b1; tag = "R5"; end
    else if (d[31]) begin inv = 1'b1; tag = "R6"; end
    else if (e == 255) begin r = '1; inv = 1'b1; tag = "R7"; end
    else if (e >= 150) begin
      if (e - 150 > 8) v = 64'h1_0000_0000;
      else v = sg << (e - 150);
      if (v >= 64'h1_0000_0000) begin r = '1; inv = 1'b1; tag = "R7"; end
      else begin r = v[31:0]; tag = "R4"; end
    end else begin
      int q;
      q = 150 - e;
      v = (q >= 25) ? 64'd0 : (sg >> q);
      inx = (q >= 25) ? 1'b1 : ((v << q) != sg);
      r = v[31:0];
      tag = inx ? "R2,R3" : "R4";
    end
  endfunction

  task automatic step(input logic v, input logic [31:0] d);
    logic [31:0] r;
    logic i, x;
    string t;
    @(negedge clk);
    checks++;
    if (out_valid !== e_valid) begin
      errors++;
      $display("FAIL R1 (%s) out_valid=%0b expected %0b", e_tag, out_valid, e_valid);
    end else if (out_data !== e_data || out_invalid !== e_inv || out_inexact !== e_inx) begin
      errors++;
      $display("FAIL %s R11 data=%h inv=%0b inx=%0b expected data=%h inv=%0b inx=%0b",
               e_tag, out_data, out_invalid, out_inexact, e_data, e_inv, e_inx);
    end
    in_valid = v;
    in_data  = d;
    e_valid  = v;
    if (v) begin
      model(d, r, i, x, t);
      e_data = r; e_inv = i; e_inx = x; e_tag = t;
    end else begin
      e_tag = "R10";
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [22:0] pat [8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // first step checks reset values (R9)
    for (int e = 0; e < 256; e++) begin
      pat[0] = 23'h0;       pat[1] = 23'h1;       pat[2] = 23'h7FFFFF;
      pat[3] = 23'h400000;  pat[4] = 23'h2AAAAA;  pat[5] = 23'h155555;
      pat[6] = 23'h000FFF;  pat[7] = 23'(e * 32'd2654435761);
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 8; k++) begin
          step(1'b1, {s[0], e[7:0], pat[k]});
          if (k == 7 && e % 16 == 0) begin
            step(1'b0, 32'hBF00_0000);   // idle with a negative operand on the bus: R10
            step(1'b0, 32'h7FC0_0000);
          end
        end
      end
    end
    // named corner operands
    step(1'b1, 32'hBF00_0000);  // -0.5: R6
    step(1'b1, 32'h3F00_0000);  // 0.5: R3
    step(1'b1, 32'h4F7F_FFFF);  // 2^32-256: R4
    step(1'b1, 32'h4F80_0000);  // 2^32: R7
    step(1'b1, 32'h7F80_0000);  // +inf: R7
    step(1'b1, 32'hFF80_0000);  // -inf: R6
    step(1'b1, 32'h8000_0001);  // negative denormal: R8
    step(1'b1, 32'h7F80_0001);  // signaling NaN: R5
    step(1'b1, 32'h3FC0_0000);  // 1.5: R2
    step(1'b0, 32'h0);
    step(1'b0, 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule